// File: doc/BRIEF.md
# Failsafe Frequency-Change Watchdog with Recovery Lock

This block guards a clock generator while its output frequency is being retuned. Software sets the watchdog enable bit before it changes the frequency. The timer does not start at that write. It starts at the next accepted frequency-change event, and each further change reloads it. If the system fails to clear the enable bit within the programmed window, the block takes three actions: it sets a sticky timeout status, it raises a recovery flag that tells the generator to load its fallback frequency and to refuse further frequency changes, and, if enabled, it pulls an active-low reset request low for a fixed number of clocks.

Time is measured in units of an external tick enable. A five-bit window field and a unit-select bit set the window length. A second, independent enable makes every accepted frequency change produce the same reset pulse, whether or not the watchdog is on. Only clearing the watchdog enable releases the recovery lock.

Top module: `wdt_recovery_lock`

## Requirements
- R1: After reset the window field is 31, the unit select is short, the watchdog enable is 0, the status is 0, both reset-pulse enables are 0, `recovery_o` is 0 and `sys_rst_no` is 1.
- R2: Once armed, expiry falls on the edge that samples tick number (W+1)*U, where W is the window field and U is `SHORT_TICKS` when the unit select (`tmo_long_i` written as 0) is short and `LONG_TICKS` when it is 1. Ticks are counted from the cycle after the arming frequency change.
- R3: While the watchdog enable is 1 the timer does not count until a frequency change arrives. With the enable at 0, ticks never cause an expiry.
- R4: A frequency change that arrives while the timer is counting reloads the full window.
- R5: On expiry `timeout_sts_o` and `recovery_o` both become 1, starting with the output sample after the expiry edge.
- R6: On expiry with the watchdog reset enable (`rsten_wd_i` written as 1) set, `sys_rst_no` is 0 for exactly `PULSE_CLKS` samples starting right after the expiry edge. With that enable at 0 it stays 1.
- R7: A status write with data 1 clears `timeout_sts_o` and a write with data 0 has no effect. An expiry in the same cycle as a clearing write leaves the status at 1.
- R8: Writing the watchdog enable as 0 stops and reloads the timer and drops `recovery_o`. A status clear alone does not drop it.
- R9: With the frequency-change reset enable (`rsten_fc_i` written as 1) set, every accepted frequency change drives `sys_rst_no` to 0 for `PULSE_CLKS` samples, even when the watchdog enable is 0.
- R10: While `recovery_o` is 1, `freq_chg_i` is ignored. It neither arms the timer nor triggers a reset pulse.
- R11: If a write that clears the enable lands on the same cycle as the final tick, the clear wins. No status, no recovery and no reset pulse result.
- R12: A new reset trigger during a pulse restarts it, so the pulse ends `PULSE_CLKS` samples after the latest trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-base enable |
| freq_chg_i | input | 1 | One-cycle frequency-change event |
| en_wr_i | input | 1 | Write strobe for the watchdog enable |
| en_wdata_i | input | 1 | Watchdog enable write data |
| tmo_wr_i | input | 1 | Write strobe for window and unit select |
| tmo_wdata_i | input | TMO_W | Window field write data |
| tmo_long_i | input | 1 | Unit select write data (1 = long unit) |
| rsten_wr_i | input | 1 | Write strobe for both reset-pulse enables |
| rsten_wd_i | input | 1 | Reset-on-expiry enable write data |
| rsten_fc_i | input | 1 | Reset-on-frequency-change enable write data |
| sts_wr_i | input | 1 | Write strobe for the status bit |
| sts_wdata_i | input | 1 | Status write data (1 clears) |
| recovery_o | output | 1 | Recovery lock flag |
| timeout_sts_o | output | 1 | Sticky timeout status |
| sys_rst_no | output | 1 | Reset request, active low |

## Verification
Every result is one register stage away from the cycle that causes it. A write, a frequency change or the final tick shows on `recovery_o`, `timeout_sts_o` or `sys_rst_no` in the first output sample after the edge that captured it. The bench drives inputs and samples outputs on the falling edge, so each check reads the state just after the capturing edge. Expiry checks sample one tick before and at tick (W+1)*U, and the bench counts delivered ticks itself when ticks are random. Pulse widths are found by counting consecutive low samples from the first sample after the trigger.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;

    // Default field width of the window count.
    localparam int unsigned WDT_TMO_W = 5;

    // Single-bit control fields owned by the watchdog.
    typedef struct packed {
        logic wd_en;      // watchdog enabled
        logic rst_on_wd;  // pulse reset on expiry
        logic rst_on_fc;  // pulse reset on frequency change
        logic long_unit;  // unit select: 1 = long
    } wdt_ctrl_t;

    localparam wdt_ctrl_t WDT_CTRL_RST = '{wd_en: 1'b0, rst_on_wd: 1'b0,
                                           rst_on_fc: 1'b0, long_unit: 1'b0};

endpackage

// File: rtl/wdt_unit_timer.sv
module wdt_unit_timer #(
    parameter int unsigned TMO_W       = 5,
    parameter int unsigned SHORT_TICKS = 3,
    parameter int unsigned LONG_TICKS  = 50
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             long_i,
    input  logic [TMO_W-1:0] window_i,
    output logic             expire_o
);

    localparam int unsigned MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned SUB_W     = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic             armed;
        logic [TMO_W-1:0] units;
        logic [SUB_W-1:0] sub;
    } tmr_t;

    tmr_t       st_d, st_q;
    logic [SUB_W-1:0] unit_last;
    logic       unit_done;
    logic       final_tick;

    always_comb begin
        st_d       = st_q;
        unit_last  = long_i ? SUB_W'(LONG_TICKS - 1) : SUB_W'(SHORT_TICKS - 1);
        unit_done  = st_q.armed && tick_i && (st_q.sub >= unit_last);
        final_tick = unit_done && (st_q.units == '0);
        expire_o   = final_tick && !start_i && !stop_i;

        if (stop_i) begin
            st_d.armed = 1'b0;
            st_d.units = window_i;
            st_d.sub   = '0;
        end else if (start_i) begin
            st_d.armed = 1'b1;
            st_d.units = window_i;
            st_d.sub   = '0;
        end else if (st_q.armed && tick_i) begin
            if (unit_done) begin
                st_d.sub = '0;
                if (st_q.units == '0) begin
                    st_d.armed = 1'b0;
                end else begin
                    st_d.units = st_q.units - 1'b1;
                end
            end else begin
                st_d.sub = st_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{armed: 1'b0, units: '1, sub: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R2: an expiry can only come out of a running timer
    assert_expire_when_armed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |-> st_q.armed);

    // R2: without a tick, start or stop the remaining count holds
    assert_hold_without_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !start_i && !stop_i) |=> $stable(st_q.units) && $stable(st_q.sub));

    // R8: a stop leaves the timer idle
    assert_stop_disarms_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !st_q.armed);

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
    parameter int unsigned PULSE_CLKS = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic rst_no
);

    localparam int unsigned CNT_W = $clog2(PULSE_CLKS + 1);

    logic [CNT_W-1:0] left_d, left_q;

    always_comb begin
        if (trig_i) begin
            left_d = CNT_W'(PULSE_CLKS);
        end else if (left_q != '0) begin
            left_d = left_q - 1'b1;
        end else begin
            left_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign rst_no = (left_q == '0);

    // R9: the request never falls without a trigger
    assert_fall_needs_trigger_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_no) |-> $past(trig_i));

    // R12: any trigger holds the request low in the next cycle
    assert_trigger_drives_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_i |=> !rst_no);

endmodule

// File: rtl/wdt_recovery_lock.sv
module wdt_recovery_lock #(
    parameter int unsigned TMO_W       = wdt_lock_pkg::WDT_TMO_W,
    parameter int unsigned SHORT_TICKS = 3,
    parameter int unsigned LONG_TICKS  = 50,
    parameter int unsigned PULSE_CLKS  = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             freq_chg_i,
    input  logic             en_wr_i,
    input  logic             en_wdata_i,
    input  logic             tmo_wr_i,
    input  logic [TMO_W-1:0] tmo_wdata_i,
    input  logic             tmo_long_i,
    input  logic             rsten_wr_i,
    input  logic             rsten_wd_i,
    input  logic             rsten_fc_i,
    input  logic             sts_wr_i,
    input  logic             sts_wdata_i,
    output logic             recovery_o,
    output logic             timeout_sts_o,
    output logic             sys_rst_no
);

    import wdt_lock_pkg::*;

    typedef struct packed {
        wdt_ctrl_t        ctrl;
        logic [TMO_W-1:0] window;
        logic             sts;
        logic             recov;
    } top_t;

    top_t st_d, st_q;

    logic en_clear;
    logic fc_accept;
    logic tmr_start;
    logic tmr_expire;
    logic rst_trig;

    wdt_unit_timer #(
        .TMO_W      (TMO_W),
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .start_i (tmr_start),
        .stop_i  (en_clear),
        .long_i  (st_q.ctrl.long_unit),
        .window_i(st_q.window),
        .expire_o(tmr_expire)
    );

    wdt_rst_stretch #(
        .PULSE_CLKS(PULSE_CLKS)
    ) u_pulse (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .trig_i(rst_trig),
        .rst_no(sys_rst_no)
    );

    always_comb begin
        st_d      = st_q;
        en_clear  = en_wr_i && !en_wdata_i;
        fc_accept = freq_chg_i && !st_q.recov;
        tmr_start = fc_accept && st_q.ctrl.wd_en;
        rst_trig  = (tmr_expire && st_q.ctrl.rst_on_wd) || (fc_accept && st_q.ctrl.rst_on_fc);

        if (tmo_wr_i) begin
            st_d.window         = tmo_wdata_i;
            st_d.ctrl.long_unit = tmo_long_i;
        end
        if (rsten_wr_i) begin
            st_d.ctrl.rst_on_wd = rsten_wd_i;
            st_d.ctrl.rst_on_fc = rsten_fc_i;
        end
        if (en_wr_i) begin
            st_d.ctrl.wd_en = en_wdata_i;
        end
        if (en_clear) begin
            st_d.recov = 1'b0;
        end
        if (sts_wr_i && sts_wdata_i) begin
            st_d.sts = 1'b0;
        end
        if (tmr_expire) begin
            st_d.sts   = 1'b1;
            st_d.recov = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ctrl: WDT_CTRL_RST, window: '1, sts: 1'b0, recov: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign recovery_o    = st_q.recov;
    assign timeout_sts_o = st_q.sts;

    // R5: entering recovery always comes with the status set
    assert_recovery_sets_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(recovery_o) |-> timeout_sts_o);

    // R8: recovery is left only through a write that clears the enable
    assert_unlock_by_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(recovery_o) |-> $past(en_wr_i && !en_wdata_i));

    // R7: status falls only on a write of 1
    assert_status_clear_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(timeout_sts_o) |-> $past(sts_wr_i && sts_wdata_i));

    // R11: an enable clear blocks entry into recovery in the same cycle
    assert_clear_beats_expiry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_wr_i && !en_wdata_i) |=> !recovery_o);

endmodule

// File: tb/tb_wdt_recovery_lock.sv
`timescale 1ns/1ps
module tb_wdt_recovery_lock;

    localparam int SHORT_T = 3;
    localparam int LONG_T  = 50;
    localparam int PULSE   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, fchg = 1'b0;
    logic       en_wr = 1'b0, en_d = 1'b0;
    logic       tmo_wr = 1'b0, tmo_l = 1'b0;
    logic [4:0] tmo_d = '0;
    logic       rs_wr = 1'b0, rs_wd = 1'b0, rs_fc = 1'b0;
    logic       st_wr = 1'b0, st_d = 1'b0;
    wire        recov, sts, srst_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wdt_recovery_lock #(
        .SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T), .PULSE_CLKS(PULSE)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freq_chg_i(fchg),
        .en_wr_i(en_wr), .en_wdata_i(en_d), .tmo_wr_i(tmo_wr), .tmo_wdata_i(tmo_d),
        .tmo_long_i(tmo_l), .rsten_wr_i(rs_wr), .rsten_wd_i(rs_wd), .rsten_fc_i(rs_fc),
        .sts_wr_i(st_wr), .sts_wdata_i(st_d),
        .recovery_o(recov), .timeout_sts_o(sts), .sys_rst_no(srst_n)
    );

    function automatic int expiry_ticks(input int w, input bit lng);
        return (w + 1) * (lng ? LONG_T : SHORT_T);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic run(input int n);
        tick = 1'b1;
        repeat (n) cyc();
        tick = 1'b0;
    endtask

    task automatic wr_en(input bit v);
        en_wr = 1'b1; en_d = v; cyc(); en_wr = 1'b0;
    endtask

    task automatic wr_tmo(input int w, input bit l);
        tmo_wr = 1'b1; tmo_d = 5'(w); tmo_l = l; cyc(); tmo_wr = 1'b0;
    endtask

    task automatic wr_rsten(input bit wd, input bit fc);
        rs_wr = 1'b1; rs_wd = wd; rs_fc = fc; cyc(); rs_wr = 1'b0;
    endtask

    task automatic wr_sts(input bit v);
        st_wr = 1'b1; st_d = v; cyc(); st_wr = 1'b0;
    endtask

    task automatic fc();
        fchg = 1'b1; cyc(); fchg = 1'b0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!srst_n && n < 100) begin
            n++;
            cyc();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    initial begin
        int n;
        int hi;
        void'($urandom(32'd4242));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1: reset state
        check("R1 recovery", recov, 0);
        check("R1 status", sts, 0);
        check("R1 reset out", srst_n, 1);

        // R3: enable alone does not start the timer
        wr_en(1'b1);
        run(200);
        check("R3 no count before change", recov, 0);

        // R1/R2/R5: default window 31, short unit -> 96 ticks
        fc();
        run(expiry_ticks(31, 1'b0) - 1);
        check("R2 default window early", recov, 0);
        run(1);
        check("R5 recovery set", recov, 1);
        check("R5 status set", sts, 1);
        check("R1 expiry reset disabled by default", srst_n, 1);

        // R10: frequency change ignored in recovery
        wr_rsten(1'b0, 1'b1);
        fc();
        hi = 1;
        repeat (20) begin
            if (!srst_n) hi = 0;
            cyc();
        end
        check("R10 no pulse in recovery", hi, 1);
        check("R10 recovery held", recov, 1);

        // R7: write 0 no effect, write 1 clears
        wr_sts(1'b0);
        check("R7 write zero ignored", sts, 1);
        wr_sts(1'b1);
        check("R7 write one clears", sts, 0);
        check("R8 status clear keeps lock", recov, 1);
        wr_en(1'b0);
        check("R8 enable clear unlocks", recov, 0);

        // R9: pulse on frequency change with watchdog off
        fc();
        count_low(n);
        check("R9 change pulse width", n, PULSE);

        // R12: retrigger restarts the pulse
        fc();
        n = 0;
        if (!srst_n) n++;
        repeat (4) begin
            cyc();
            if (!srst_n) n++;
        end
        fc();
        begin
            int m;
            count_low(m);
            n += m;
        end
        check("R12 retrigger width", n, 4 + 1 + PULSE);

        // R6: reset pulse on expiry, window 2 short
        wr_rsten(1'b1, 1'b0);
        wr_tmo(2, 1'b0);
        wr_en(1'b1);
        fc();
        run(expiry_ticks(2, 1'b0) - 1);
        check("R6 no pulse before expiry", srst_n, 1);
        run(1);
        check("R5 recovery on window 2", recov, 1);
        count_low(n);
        check("R6 expiry pulse width", n, PULSE);
        wr_sts(1'b1);
        wr_en(1'b0);

        // R2: long unit, window 0 -> 50 ticks
        wr_rsten(1'b0, 1'b0);
        wr_tmo(0, 1'b1);
        wr_en(1'b1);
        fc();
        run(expiry_ticks(0, 1'b1) - 1);
        check("R2 long unit early", recov, 0);
        run(1);
        check("R2 long unit expiry", recov, 1);
        wr_sts(1'b1);
        wr_en(1'b0);

        // R4: reload on repeated change
        wr_tmo(1, 1'b0);
        wr_en(1'b1);
        fc();
        run(4);
        fc();
        run(expiry_ticks(1, 1'b0) - 1);
        check("R4 reload delays expiry", recov, 0);
        run(1);
        check("R4 expiry after reload", recov, 1);
        wr_en(1'b0);
        check("R8 unlock keeps status", sts, 1);

        // R7: set wins over same-cycle clear
        wr_tmo(0, 1'b0);
        wr_en(1'b1);
        fc();
        run(2);
        tick = 1'b1; st_wr = 1'b1; st_d = 1'b1;
        cyc();
        tick = 1'b0; st_wr = 1'b0;
        check("R7 expiry beats clear", sts, 1);
        wr_sts(1'b1);
        wr_en(1'b0);

        // R11: enable clear beats expiry; R8: timer stays stopped
        wr_rsten(1'b1, 1'b0);
        wr_en(1'b1);
        fc();
        run(2);
        tick = 1'b1; en_wr = 1'b1; en_d = 1'b0;
        cyc();
        en_wr = 1'b0;
        check("R11 no recovery", recov, 0);
        check("R11 no status", sts, 0);
        check("R11 no pulse", srst_n, 1);
        run(30);
        check("R8 stopped timer silent", recov, 0);

        // R2/R6 random: window, reset enable and tick spacing drawn at random
        for (int it = 0; it < 20; it++) begin
            int w;
            int got;
            int need;
            bit rwd;
            bit early;
            w    = int'($urandom % 6);
            rwd  = 1'($urandom % 2);
            need = expiry_ticks(w, 1'b0);
            wr_rsten(rwd, 1'b0);
            wr_tmo(w, 1'b0);
            wr_en(1'b1);
            fc();
            got = 0;
            early = 1'b0;
            while (got < need) begin
                tick = 1'($urandom % 2);
                cyc();
                if (tick) got++;
                if (got < need && recov) early = 1'b1;
            end
            tick = 1'b0;
            check("R2 random no early expiry", int'(early), 0);
            check("R5 random expiry", recov, 1);
            check("R6 random pulse select", srst_n, rwd ? 0 : 1);
            wr_sts(1'b1);
            wr_en(1'b0);
            repeat (PULSE + 2) cyc();
        end

        finish_run();
    end

endmodule